// File: doc/BRIEF.md
# ATA PIO Command Sequencer

This block is the host-side controller that runs one ATA command over a narrow register-access port. A single start pulse hands it an opcode and a device number. The block first masks the device interrupt through the control block. It then waits until the device is idle and reports ready, selects the device, and writes the opcode. It follows the command's status to one of four endings: a 256-word PIO read, a command with no data, a device error, or a timeout.

Every register access takes one clock cycle. The block drives a command-block select or a control-block select, a 3-bit register offset, and a read or write strobe. The device answers a read with `reg_rdata` in the same cycle. Words read from the data register pass straight to a valid/ready stream: a data read is issued only in a cycle where the consumer accepts the word. When the command ends, a one-cycle `done` pulse is raised, and the result flags and error byte stay valid until the next accepted start.

The states are:
- IDLE: waits for start.
- MASK: writes the control register.
- WAIT_BSY: polls status until it is not busy.
- WAIT_RDY: polls status until it reports ready.
- SELECT: writes drive/head.
- COMMAND: writes the opcode.
- WAIT_DRQ: polls status after the command.
- XFER: streams the data words.
- RD_ERR: reads the error register.
- FIN: pulses done.

The transitions are:
- IDLE→MASK on start.
- MASK→WAIT_BSY.
- WAIT_BSY→WAIT_RDY when busy clears.
- WAIT_RDY→SELECT when ready is seen.
- SELECT→COMMAND→WAIT_DRQ.
- WAIT_DRQ→XFER on a data request.
- WAIT_DRQ→RD_ERR on error or fault.
- WAIT_DRQ→FIN when the device is neither busy nor requesting.
- XFER→FIN after the last word.
- RD_ERR→FIN.
- Any wait state→FIN on timeout.
- FIN→IDLE.

Top module: `ata_pio_seq`

## Requirements
- R1: After reset the block is idle: no select, no strobe, `out_valid`, `done`, `err_flag` and `tmo_flag` all 0.
- R2: The first access after an accepted start is a control-block write to offset 6 with data 0x02, which sets the interrupt-mask bit (bit 1).
- R3: Status (command-block offset 7, read) is read once per cycle until bit 7 (busy) reads 0. After that it is read until bit 6 (ready) reads 1. The drive/head write happens only after a status read showed bit 6 set.
- R4: After the ready poll, the block writes drive/head (offset 6) with 0x00 for device 0 or 0x10 for device 1. In the next cycle it writes the captured opcode to offset 7.
- R5: After the command, status is polled while bit 7 is 1. Once bit 7 is 0, bit 0 (error) or bit 5 (fault) set causes one read of offset 1; that byte goes to `err_code` and `err_flag` is set. Otherwise bit 3 (data request) set starts the transfer. If none of these bits is set, the command finishes with no data and no flag.
- R6: The transfer moves exactly 256 words from offset 0. Each accepted beat is exactly one device read, and `out_data` carries the word read in that cycle. With `out_ready` low, no read is issued.
- R7: A wait state ends the command with `tmo_flag` when `poll_limit` consecutive reads in that state fail its condition. A read that meets the condition at the limit still advances. A `poll_limit` of 0 disables the timeout.
- R8: A start pulse while a command is in progress is ignored: no second command is issued, and the opcode in use does not change.
- R9: `done` is high for exactly one cycle, in the cycle after the final access. The result flags and `err_code` hold until the next accepted start.
- R10: No cycle has both a read and a write strobe, or both selects, and every strobe comes with a select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start pulse, accepted in IDLE only |
| cmd_op | input | 8 | Command opcode, captured at start |
| dev_sel | input | 1 | Device number, captured at start |
| poll_limit | input | POLL_W | Failed polls allowed per wait state (0 = no limit) |
| cs_cmd | output | 1 | Command-block select |
| cs_ctl | output | 1 | Control-block select |
| reg_addr | output | 3 | Register offset |
| reg_rd | output | 1 | Read strobe |
| reg_wr | output | 1 | Write strobe |
| reg_wdata | output | 16 | Write data |
| reg_rdata | input | 16 | Read data, valid in the strobe cycle |
| out_valid | output | 1 | Stream word valid |
| out_data | output | 16 | Stream word |
| out_ready | input | 1 | Stream consumer ready |
| done | output | 1 | One-cycle completion pulse |
| err_flag | output | 1 | Device reported error or fault |
| tmo_flag | output | 1 | A wait state timed out |
| err_code | output | 8 | Error register byte |

## Verification
With the start pulse sampled at clock edge 0, the mask write is in cycle 1. Each poll takes one cycle per status read. `done` rises in the cycle after the last access. For a run with 2 busy reads, 3 not-ready reads, 3 busy reads after the command and an always-ready consumer, `done` is due in cycle 271. The bench counts negative edges from the start edge and checks that exact cycle. Timeout checks count the status reads the device model served, so they are checked against `poll_limit` exactly. Flags and stream words are sampled at the negative edge of the cycle they belong to, or counted at the posedge where a beat is accepted.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_MASK,
        S_WAIT_BSY,
        S_WAIT_RDY,
        S_SELECT,
        S_COMMAND,
        S_WAIT_DRQ,
        S_XFER,
        S_RD_ERR,
        S_FIN
    } seq_state_e;

    // command-block offsets
    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_ERR  = 3'd1;
    localparam logic [2:0] OFS_DEV  = 3'd6;
    localparam logic [2:0] OFS_STAT = 3'd7;
    localparam logic [2:0] OFS_CMD  = 3'd7;
    // control-block offset
    localparam logic [2:0] OFS_CTL  = 3'd6;

    // status bit positions
    localparam int unsigned SB_BSY  = 7;
    localparam int unsigned SB_DRDY = 6;
    localparam int unsigned SB_DF   = 5;
    localparam int unsigned SB_DRQ  = 3;
    localparam int unsigned SB_ERR  = 0;

    localparam int unsigned MASK_BIT = 1;
    localparam int unsigned DEV_BIT  = 4;

endpackage

// File: rtl/ata_poll_timer.sv
module ata_poll_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         fail,
    input  logic [W-1:0] limit,
    output logic         expired
);

    logic [W-1:0] cnt_q;
    logic [W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + (W+1)'(1);
    // limit 0 can never match, so the timeout is off
    assign expired = fail && (cnt_inc == {1'b0, limit});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (fail) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

endmodule

// File: rtl/ata_beat_counter.sv
module ata_beat_counter #(
    parameter int unsigned WORDS = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic beat,
    output logic last
);

    localparam int unsigned CW = $clog2(WORDS);

    logic [CW-1:0] cnt_q;

    assign last = beat && (cnt_q == CW'(WORDS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (beat) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
    import ata_seq_pkg::*;
#(
    parameter int unsigned POLL_W = 16,
    parameter int unsigned WORDS  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        cmd_op,
    input  logic              dev_sel,
    input  logic [POLL_W-1:0] poll_limit,
    output logic              cs_cmd,
    output logic              cs_ctl,
    output logic [2:0]        reg_addr,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [15:0]       reg_wdata,
    input  logic [15:0]       reg_rdata,
    output logic              out_valid,
    output logic [15:0]       out_data,
    input  logic              out_ready,
    output logic              done,
    output logic              err_flag,
    output logic              tmo_flag,
    output logic [7:0]        err_code
);

    seq_state_e state_q, state_d;
    logic [7:0] cmd_q;
    logic       dev_q;
    logic [7:0] st;
    logic       accept;
    logic       poll_fail;
    logic       tmo_hit;
    logic       beat;
    logic       last_beat;

    assign st     = reg_rdata[7:0];
    assign accept = (state_q == S_IDLE) && start;
    assign beat   = (state_q == S_XFER) && out_ready;

    always_comb begin
        poll_fail = 1'b0;
        unique case (state_q)
            S_WAIT_BSY: poll_fail = st[SB_BSY];
            S_WAIT_RDY: poll_fail = !st[SB_DRDY];
            S_WAIT_DRQ: poll_fail = st[SB_BSY];
            default:    poll_fail = 1'b0;
        endcase
    end

    ata_poll_timer #(.W(POLL_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_d != state_q),
        .fail    (poll_fail),
        .limit   (poll_limit),
        .expired (tmo_hit)
    );

    ata_beat_counter #(.WORDS(WORDS)) u_beats (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .beat  (beat),
        .last  (last_beat)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start) state_d = S_MASK;
            S_MASK:     state_d = S_WAIT_BSY;
            S_WAIT_BSY: begin
                if (!st[SB_BSY])   state_d = S_WAIT_RDY;
                else if (tmo_hit)  state_d = S_FIN;
            end
            S_WAIT_RDY: begin
                if (st[SB_DRDY])   state_d = S_SELECT;
                else if (tmo_hit)  state_d = S_FIN;
            end
            S_SELECT:   state_d = S_COMMAND;
            S_COMMAND:  state_d = S_WAIT_DRQ;
            S_WAIT_DRQ: begin
                if (st[SB_BSY]) begin
                    if (tmo_hit) state_d = S_FIN;
                end else if (st[SB_ERR] || st[SB_DF]) begin
                    state_d = S_RD_ERR;
                end else if (st[SB_DRQ]) begin
                    state_d = S_XFER;
                end else begin
                    state_d = S_FIN;
                end
            end
            S_XFER:     if (last_beat) state_d = S_FIN;
            S_RD_ERR:   state_d = S_FIN;
            S_FIN:      state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        cs_cmd    = 1'b0;
        cs_ctl    = 1'b0;
        reg_addr  = OFS_DATA;
        reg_rd    = 1'b0;
        reg_wr    = 1'b0;
        reg_wdata = '0;
        out_valid = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            S_MASK: begin
                cs_ctl              = 1'b1;
                reg_addr            = OFS_CTL;
                reg_wr              = 1'b1;
                reg_wdata[MASK_BIT] = 1'b1;
            end
            S_WAIT_BSY, S_WAIT_RDY, S_WAIT_DRQ: begin
                cs_cmd   = 1'b1;
                reg_addr = OFS_STAT;
                reg_rd   = 1'b1;
            end
            S_SELECT: begin
                cs_cmd             = 1'b1;
                reg_addr           = OFS_DEV;
                reg_wr             = 1'b1;
                reg_wdata[DEV_BIT] = dev_q;
            end
            S_COMMAND: begin
                cs_cmd         = 1'b1;
                reg_addr       = OFS_CMD;
                reg_wr         = 1'b1;
                reg_wdata[7:0] = cmd_q;
            end
            S_XFER: begin
                cs_cmd    = 1'b1;
                reg_addr  = OFS_DATA;
                reg_rd    = out_ready;
                out_valid = 1'b1;
            end
            S_RD_ERR: begin
                cs_cmd   = 1'b1;
                reg_addr = OFS_ERR;
                reg_rd   = 1'b1;
            end
            S_FIN:   done = 1'b1;
            default: ;
        endcase
    end

    assign out_data = reg_rdata;

    // captured command and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            dev_q    <= 1'b0;
            err_flag <= 1'b0;
            tmo_flag <= 1'b0;
            err_code <= '0;
        end else if (accept) begin
            cmd_q    <= cmd_op;
            dev_q    <= dev_sel;
            err_flag <= 1'b0;
            tmo_flag <= 1'b0;
            err_code <= '0;
        end else if (state_q == S_RD_ERR) begin
            err_flag <= 1'b1;
            err_code <= st;
        end else if (tmo_hit) begin
            tmo_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/ata_pio_seq_chk.sv
module ata_pio_seq_chk
    import ata_seq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input seq_state_e  state_q,
    input logic        cs_cmd,
    input logic        cs_ctl,
    input logic [2:0]  reg_addr,
    input logic        reg_rd,
    input logic        reg_wr,
    input logic [15:0] reg_wdata,
    input logic        out_valid,
    input logic        out_ready,
    input logic        done,
    input logic        err_flag,
    input logic        tmo_flag
);

    a_r2_mask_first: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q == S_IDLE) |=>
            (reg_wr && cs_ctl && !cs_cmd && reg_addr == OFS_CTL && reg_wdata[MASK_BIT]));

    a_r4_cmd_after_select: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && cs_cmd && reg_addr == OFS_CMD) |->
            $past(reg_wr && cs_cmd && reg_addr == OFS_DEV));

    a_r6_read_follows_ready: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (reg_rd == out_ready && cs_cmd && reg_addr == OFS_DATA));

    a_r7_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(err_flag && tmo_flag));

    a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q != S_IDLE && state_q != S_FIN) |=> (state_q != S_MASK));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr) && !(cs_cmd && cs_ctl));

    a_r10_strobe_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd || reg_wr) |-> (cs_cmd || cs_ctl));

endmodule

bind ata_pio_seq ata_pio_seq_chk u_chk (.*);

// File: tb/ata_pio_seq_bench.sv
module ata_pio_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  cmd_op = 8'h00;
    logic        dev_sel = 1'b0;
    logic [15:0] poll_limit = 16'd0;
    logic        cs_cmd, cs_ctl, reg_rd, reg_wr;
    logic [2:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata, out_data;
    logic        out_valid, out_ready, done, err_flag, tmo_flag;
    logic [7:0]  err_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_pio_seq u_ata_pio_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_op(cmd_op),
        .dev_sel(dev_sel), .poll_limit(poll_limit), .cs_cmd(cs_cmd),
        .cs_ctl(cs_ctl), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .done(done), .err_flag(err_flag), .tmo_flag(tmo_flag),
        .err_code(err_code)
    );

    int tests = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    int         cfg_bsy = 0, cfg_rdy = 0, cfg_drq = 0, cfg_mode = 0, rdy_pat = 0;
    logic [7:0] cfg_err = 8'h00;
    logic       mdl_clr = 1'b0;

    bit         phase;
    int         sreads, tot_reads, ph1_reads, widx, wcnt;
    bit         drdy_seen, sel_ok;
    logic [7:0] wl_data [0:7];
    logic [2:0] wl_addr [0:7];
    bit         wl_ctl  [0:7];
    logic [7:0] stat_v;

    function automatic logic [15:0] wordval(input int i);
        return {8'h5A ^ 8'(i), 8'(i)};
    endfunction

    always_comb begin
        if (!phase) begin
            if (sreads < cfg_bsy)                stat_v = 8'h80;
            else if (sreads < cfg_bsy + cfg_rdy) stat_v = 8'h00;
            else                                 stat_v = 8'h50;
        end else if (sreads < cfg_drq) begin
            stat_v = 8'hD0;
        end else begin
            case (cfg_mode)
                0:       stat_v = 8'h58;  // data request
                1:       stat_v = 8'h51;  // error
                2:       stat_v = 8'h50;  // no data
                3:       stat_v = 8'hD0;  // stuck busy
                default: stat_v = 8'h70;  // fault
            endcase
        end
        reg_rdata = 16'h0000;
        if (cs_cmd) begin
            case (reg_addr)
                3'd7:    reg_rdata = {8'h00, stat_v};
                3'd1:    reg_rdata = {8'h00, cfg_err};
                3'd0:    reg_rdata = wordval(widx);
                default: reg_rdata = 16'h0000;
            endcase
        end
    end

    always @(posedge clk) begin
        if (mdl_clr) begin
            phase <= 0; sreads <= 0; tot_reads <= 0; ph1_reads <= 0;
            widx <= 0; wcnt <= 0; drdy_seen <= 0; sel_ok <= 0;
        end else begin
            if (reg_rd && cs_cmd && reg_addr == 3'd7) begin
                sreads    <= sreads + 1;
                tot_reads <= tot_reads + 1;
                if (phase) ph1_reads <= ph1_reads + 1;
                if (!phase && stat_v[6]) drdy_seen <= 1;
            end
            if (reg_rd && cs_cmd && reg_addr == 3'd0) widx <= widx + 1;
            if (reg_wr) begin
                if (wcnt < 8) begin
                    wl_data[wcnt] <= reg_wdata[7:0];
                    wl_addr[wcnt] <= reg_addr;
                    wl_ctl[wcnt]  <= cs_ctl;
                end
                wcnt <= wcnt + 1;
                if (cs_cmd && reg_addr == 3'd6) sel_ok <= drdy_seen;
                if (cs_cmd && reg_addr == 3'd7) begin
                    phase  <= 1;
                    sreads <= 0;
                end
            end
        end
    end

    // ---------------- stream consumer ----------------
    int ncyc = 0;
    int rx_n, rx_bad;

    always @(negedge clk) begin
        ncyc      <= ncyc + 1;
        out_ready <= (rdy_pat == 0) ? 1'b1 : ((ncyc % 3) != 0);
    end

    always @(posedge clk) begin
        if (mdl_clr) begin
            rx_n <= 0; rx_bad <= 0;
        end else if (out_valid && out_ready) begin
            if (out_data !== wordval(rx_n)) rx_bad <= rx_bad + 1;
            rx_n <= rx_n + 1;
        end
    end

    // ---------------- run one command ----------------
    int cyc;
    bit dn;

    task automatic run(input logic [7:0] op, input bit dev, input logic [15:0] lim,
                       input int b, input int r, input int d, input int m,
                       input logic [7:0] ev, input int pat, input bit poke);
        cfg_bsy = b; cfg_rdy = r; cfg_drq = d; cfg_mode = m; cfg_err = ev;
        rdy_pat = pat; cmd_op = op; dev_sel = dev; poll_limit = lim;
        @(negedge clk); mdl_clr = 1'b1;
        @(negedge clk); mdl_clr = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 1; dn = 0;
        while (cyc < 20000 && !dn) begin
            if (done) begin
                dn = 1;
            end else begin
                if (poke && cyc == 40) begin start = 1'b1; cmd_op = 8'h00; dev_sel = 1'b1; end
                if (poke && cyc == 41) start = 1'b0;
                @(negedge clk);
                cyc++;
            end
        end
        chk(dn, "R9", "done seen", dn, 1);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(!cs_cmd && !cs_ctl && !reg_rd && !reg_wr, "R1", "no access at reset",
            {cs_cmd, cs_ctl, reg_rd, reg_wr}, 0);
        chk(!out_valid && !done, "R1", "valid/done low", {out_valid, done}, 0);
        chk(!err_flag && !tmo_flag, "R1", "flags low", {err_flag, tmo_flag}, 0);
    endtask

    task automatic t_identify();
        run(8'hEC, 1'b0, 16'd100, 2, 4, 3, 0, 8'h00, 0, 0);
        chk(cyc == 271, "R9", "done cycle", cyc, 271);
        chk(wcnt == 3, "R4", "write count", wcnt, 3);
        chk(wl_ctl[0] && wl_addr[0] == 3'd6 && wl_data[0] == 8'h02, "R2", "mask write",
            wl_data[0], 8'h02);
        chk(!wl_ctl[1] && wl_addr[1] == 3'd6 && wl_data[1] == 8'h00, "R4", "select dev0",
            wl_data[1], 8'h00);
        chk(!wl_ctl[2] && wl_addr[2] == 3'd7 && wl_data[2] == 8'hEC, "R4", "opcode",
            wl_data[2], 8'hEC);
        chk(sel_ok, "R3", "select after ready", sel_ok, 1);
        chk(tot_reads == 11, "R3", "status reads", tot_reads, 11);
        chk(rx_n == WORDS && rx_bad == 0, "R6", "words received", rx_n, WORDS);
        chk(!err_flag && !tmo_flag, "R5", "clean flags", {err_flag, tmo_flag}, 0);
        @(negedge clk);
        chk(!done, "R9", "done one cycle", done, 0);
    endtask

    task automatic t_backpressure();
        run(8'hEC, 1'b1, 16'd100, 1, 1, 2, 0, 8'h00, 1, 0);
        chk(wl_data[1] == 8'h10, "R4", "select dev1", wl_data[1], 8'h10);
        chk(rx_n == WORDS && rx_bad == 0, "R6", "words under backpressure", rx_n, WORDS);
        chk(widx == WORDS, "R6", "device data reads", widx, WORDS);
    endtask

    task automatic t_error(input int mode, input logic [7:0] ev);
        run(8'hEC, 1'b0, 16'd100, 0, 0, 2, mode, ev, 0, 0);
        chk(err_flag && !tmo_flag, "R5", "error flag", {err_flag, tmo_flag}, 2);
        chk(err_code == ev, "R5", "error byte", err_code, ev);
        chk(rx_n == 0 && widx == 0, "R5", "no data on error", rx_n, 0);
        repeat (3) @(negedge clk);
        chk(err_flag && err_code == ev, "R9", "error result held", err_code, ev);
    endtask

    task automatic t_nodata();
        run(8'hE7, 1'b0, 16'd100, 0, 0, 4, 2, 8'h00, 0, 0);
        chk(!err_flag && !tmo_flag, "R5", "non-data flags", {err_flag, tmo_flag}, 0);
        chk(rx_n == 0 && widx == 0, "R5", "non-data no words", widx, 0);
        chk(ph1_reads == 5, "R5", "post-command polls", ph1_reads, 5);
    endtask

    task automatic t_tmo_edge();
        run(8'hEC, 1'b0, 16'd3, 3, 0, 0, 0, 8'h00, 0, 0);
        chk(tmo_flag && !err_flag, "R7", "timeout at limit", tmo_flag, 1);
        chk(tot_reads == 3 && wcnt == 1, "R7", "reads before timeout", tot_reads, 3);
        run(8'hEC, 1'b0, 16'd4, 3, 0, 0, 0, 8'h00, 0, 0);
        chk(!tmo_flag && rx_n == WORDS, "R7", "success on last allowed poll", rx_n, WORDS);
    endtask

    task automatic t_tmo_states();
        run(8'hEC, 1'b0, 16'd2, 0, 10, 0, 0, 8'h00, 0, 0);
        chk(tmo_flag && tot_reads == 3 && wcnt == 1, "R7", "ready-wait timeout",
            tot_reads, 3);
        run(8'hEC, 1'b0, 16'd5, 0, 0, 1000, 3, 8'h00, 0, 0);
        chk(tmo_flag && wcnt == 3 && ph1_reads == 5, "R7", "drq-wait timeout",
            ph1_reads, 5);
    endtask

    task automatic t_nolimit();
        run(8'hEC, 1'b0, 16'd0, 300, 0, 0, 0, 8'h00, 0, 0);
        chk(!tmo_flag && rx_n == WORDS, "R7", "limit zero never expires", tmo_flag, 0);
    endtask

    task automatic t_busy_start();
        run(8'hEC, 1'b0, 16'd100, 2, 4, 3, 0, 8'h00, 0, 1);
        chk(wcnt == 3 && wl_data[2] == 8'hEC, "R8", "single command kept", wcnt, 3);
        chk(rx_n == WORDS, "R8", "transfer unaffected", rx_n, WORDS);
        repeat (5) @(negedge clk);
        chk(!reg_rd && !reg_wr && !cs_ctl && wcnt == 3, "R8", "no restart",
            {reg_rd, reg_wr}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_identify();
        t_backpressure();
        t_error(1, 8'h04);
        t_error(4, 8'h10);
        t_nodata();
        t_tmo_edge();
        t_tmo_states();
        t_nolimit();
        t_busy_start();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule